// File: doc/BRIEF.md
# Interrupt Entry and Vectoring Sequencer

This block performs the entry half of interrupt handling for a small 8-bit microcontroller core. It holds a register of pending interrupt requests, a global interrupt enable flag and a byte-wide stack pointer. When a reset request arrives, or when interrupts are enabled and a request is pending, it selects one source and saves the current program counter on the stack. It then clears the enable flag and drops the serviced request. Last, it presents the new program counter taken from the vector table.

The return address goes out through a byte-wide data-memory write port, one byte per clock, with the stack pointer moving down after each write. Two configuration inputs choose how many bytes the return address takes and whether each vector-table slot is one or two words wide. Instruction decode, the return-from-interrupt path and the peripherals that raise requests belong to other blocks.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the pending register and the enable flag are zero, the stack pointer equals SP_INIT, and busy, mem_we and taken are low.
- R2: A reset request seen while idle starts an entry with vector 0. It does so whatever the enable flag and the pending register hold, and it leaves the pending register unchanged.
- R3: A hardware entry starts only when the enable flag is 1 and at least one pending bit is set. Otherwise nothing is written and taken stays low.
- R4: Among the pending bits the lowest-numbered one is served. taken_vec carries its index plus 1.
- R5: new_pc equals VEC_BASE plus the vector number times the slot size. The slot size is 2 when cfg_long_slot is 1 and 1 when it is 0.
- R6: Return-address bytes are written least significant first: bits 7:0 at the stack pointer, then bits 15:8 at one below, then bits 23:16 at two below. After each write the stack pointer is one lower.
- R7: cfg_pc_bytes = 3 pushes three bytes, 2 pushes two, and 0 or 1 pushes one.
- R8: The enable flag is 0 from the clock edge that accepts an entry onward.
- R9: A hardware entry clears only the served pending bit. All other pending bits stay set.
- R10: A bit raised on irq_set always becomes set in the pending register on the next edge, including during an entry.
- R11: The entry is accepted on the clock edge after the request. The writes follow on consecutive cycles, and taken is high for exactly one cycle, the cycle right after the last write.
- R12: While busy is high, sp_wr and gie_wr have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set | input | NUM_SRC | Request bits ORed into the pending register |
| reset_req | input | 1 | Reset request, vector 0 |
| cur_pc | input | PC_W | Return address to save |
| cfg_pc_bytes | input | 2 | Return-address byte count (3, 2, else 1) |
| cfg_long_slot | input | 1 | 1: two-word vector slots |
| gie_wr | input | 1 | Write strobe for the enable flag (idle only) |
| gie_wdata | input | 1 | Value for the enable flag |
| sp_wr | input | 1 | Write strobe for the stack pointer (idle only) |
| sp_wdata | input | SP_W | Value for the stack pointer |
| gie | output | 1 | Global interrupt enable flag |
| sp | output | SP_W | Stack pointer |
| pending | output | NUM_SRC | Pending register |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | SP_W | Stack write address |
| mem_wdata | output | 8 | Stack write byte |
| taken | output | 1 | One-cycle entry completion pulse |
| taken_vec | output | VEC_W | Vector number served |
| new_pc | output | PC_W | Program counter to load, valid with taken |

## Verification
Counting from the clock edge that accepts a request, the first stack byte is due in the cycle after that edge. Further bytes follow one cycle apart, and taken with new_pc arrives one cycle after the last byte. The enable flag and the served pending bit change at the accepting edge itself, and the stack pointer settles one edge after the last write. The bench drives inputs on falling edges and samples every output on the falling edge of each cycle after acceptance. It records the cycle in which each write and the taken pulse appear, and compares those cycle numbers with the expected ones as well as the values.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PUSH0  = 3'd1,
      ST_PUSH1  = 3'd2,
      ST_PUSH2  = 3'd3,
      ST_VECTOR = 3'd4
   } seq_state_t;

   localparam int RET_BYTES_MAX = 3;
   localparam int RET_W         = 8 * RET_BYTES_MAX;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 4
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               any,
   output logic [VEC_W-1:0]   vec,
   output logic [NUM_SRC-1:0] clr_mask
);
   logic [NUM_SRC-1:0] lower_seen;

   assign any = |pend;

   // lower_seen[i] is set when some bit below i is pending
   assign lower_seen[0] = 1'b0;
   for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
      assign lower_seen[i] = lower_seen[i-1] | pend[i-1];
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      assign clr_mask[i] = pend[i] & ~lower_seen[i];
   end

   always_comb begin
      vec = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (clr_mask[i]) vec = VEC_W'(i + 1);
      end
   end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] clr_mask,
   output logic [NUM_SRC-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else if (clr_en) pend <= (pend & ~clr_mask) | set;
      else pend <= pend | set;
   end

   assert_set_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((pend & $past(set)) == $past(set)));

   assert_single_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && set == '0 && pend != '0) |=> ($countones(pend) == $countones($past(pend)) - 1));
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int          PC_W            = 22,
   parameter int          VEC_W           = 4,
   parameter logic [23:0] VEC_BASE        = 24'h0,
   parameter bit          ALLOW_LONG_SLOT = 1'b1
) (
   input  logic [VEC_W-1:0] vec,
   input  logic             long_slot,
   output logic [PC_W-1:0]  target
);
   logic [PC_W-1:0] offset;

   if (ALLOW_LONG_SLOT) begin : g_sel_slot
      assign offset = long_slot ? (PC_W'(vec) << 1) : PC_W'(vec);
   end else begin : g_short_slot
      logic unused_long;
      assign unused_long = long_slot;
      assign offset = PC_W'(vec);
   end

   assign target = VEC_BASE[PC_W-1:0] + offset;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int          NUM_SRC         = 8,
   parameter int          PC_W            = 22,
   parameter int          SP_W            = 16,
   parameter logic [15:0] SP_INIT         = 16'h08FF,
   parameter logic [23:0] VEC_BASE        = 24'h0,
   parameter bit          ALLOW_LONG_SLOT = 1'b1,
   localparam int         VEC_W           = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_set,
   input  logic               reset_req,
   input  logic [PC_W-1:0]    cur_pc,
   input  logic [1:0]         cfg_pc_bytes,
   input  logic               cfg_long_slot,
   input  logic               gie_wr,
   input  logic               gie_wdata,
   input  logic               sp_wr,
   input  logic [SP_W-1:0]    sp_wdata,
   output logic               gie,
   output logic [SP_W-1:0]    sp,
   output logic [NUM_SRC-1:0] pending,
   output logic               busy,
   output logic               mem_we,
   output logic [SP_W-1:0]    mem_addr,
   output logic [7:0]         mem_wdata,
   output logic               taken,
   output logic [VEC_W-1:0]   taken_vec,
   output logic [PC_W-1:0]    new_pc
);
   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (PC_W < 8 || PC_W > RET_W) begin : g_bad_pcw
      $error("PC_W out of range");
   end
   if (SP_W < 8 || SP_W > 16) begin : g_bad_spw
      $error("SP_W out of range");
   end

   seq_state_t          state_q, state_d;
   logic [RET_W-1:0]    ret_q;
   logic [1:0]          nbytes_q;
   logic [VEC_W-1:0]    vec_q;
   logic                long_q;
   logic                pick_any;
   logic [VEC_W-1:0]    pick_vec;
   logic [NUM_SRC-1:0]  pick_clr;
   logic                idle, take_rst, take_irq, start;
   logic [1:0]          nbytes_d;

   assign idle     = (state_q == ST_IDLE);
   assign take_rst = idle && reset_req;
   assign take_irq = idle && !reset_req && gie && pick_any;
   assign start    = take_rst || take_irq;

   irq_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
      .pend     (pending),
      .any      (pick_any),
      .vec      (pick_vec),
      .clr_mask (pick_clr)
   );

   irq_pending_reg #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (irq_set),
      .clr_en   (take_irq),
      .clr_mask (pick_clr),
      .pend     (pending)
   );

   irq_vec_addr #(
      .PC_W(PC_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .ALLOW_LONG_SLOT(ALLOW_LONG_SLOT)
   ) u_vaddr (
      .vec       (vec_q),
      .long_slot (long_q),
      .target    (new_pc)
   );

   always_comb begin
      unique case (cfg_pc_bytes)
         2'd3:    nbytes_d = 2'd3;
         2'd2:    nbytes_d = 2'd2;
         default: nbytes_d = 2'd1;
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start) state_d = ST_PUSH0;
         ST_PUSH0:  state_d = (nbytes_q >= 2'd2) ? ST_PUSH1 : ST_VECTOR;
         ST_PUSH1:  state_d = (nbytes_q == 2'd3) ? ST_PUSH2 : ST_VECTOR;
         ST_PUSH2:  state_d = ST_VECTOR;
         ST_VECTOR: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ret_q    <= '0;
         nbytes_q <= 2'd1;
         vec_q    <= '0;
         long_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start) begin
            ret_q    <= RET_W'(cur_pc);
            nbytes_q <= nbytes_d;
            vec_q    <= take_rst ? '0 : pick_vec;
            long_q   <= cfg_long_slot;
         end
      end
   end

   // enable flag: entry clears it, core writes only while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gie <= 1'b0;
      else if (start) gie <= 1'b0;
      else if (idle && gie_wr) gie <= gie_wdata;
   end

   // stack pointer: core writes while idle, post-decrement on each push
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp <= SP_INIT[SP_W-1:0];
      else if (mem_we) sp <= sp - 1'b1;
      else if (idle && sp_wr) sp <= sp_wdata;
   end

   assign busy      = !idle;
   assign mem_we    = (state_q == ST_PUSH0) || (state_q == ST_PUSH1) || (state_q == ST_PUSH2);
   assign mem_addr  = sp;
   assign taken     = (state_q == ST_VECTOR);
   assign taken_vec = vec_q;

   always_comb begin
      unique case (state_q)
         ST_PUSH1: mem_wdata = ret_q[15:8];
         ST_PUSH2: mem_wdata = ret_q[23:16];
         default:  mem_wdata = ret_q[7:0];
      endcase
   end

   assert_reset_vec0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reset_req) |=> (busy && vec_q == '0));

   assert_no_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !reset_req && (!gie || pending == '0)) |=> !busy);

   assert_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq) |=> (taken_vec != '0 && !pending[taken_vec - 1'b1]) || $past(irq_set) != '0);

   assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == $past(mem_addr) - 1'b1));

   assert_gie_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> !gie);

   assert_taken_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !taken);

   assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_we) |=> $stable(sp));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   localparam int NSRC = 8;
   localparam int PCW  = 22;
   localparam int SPW  = 16;
   localparam logic [15:0] SPI = 16'h08FF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NSRC-1:0] irq_set = '0;
   logic reset_req = 1'b0;
   logic [PCW-1:0] cur_pc = '0;
   logic [1:0] cfg_pc_bytes = 2'd1;
   logic cfg_long_slot = 1'b0;
   logic gie_wr = 1'b0, gie_wdata = 1'b0, sp_wr = 1'b0;
   logic [SPW-1:0] sp_wdata = '0;
   logic gie, busy, mem_we, taken;
   logic [SPW-1:0] sp, mem_addr;
   logic [NSRC-1:0] pending;
   logic [7:0] mem_wdata;
   logic [3:0] taken_vec;
   logic [PCW-1:0] new_pc;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_entry_seq #(.NUM_SRC(NSRC), .PC_W(PCW), .SP_W(SPW), .SP_INIT(SPI)) u_irq_entry_seq (
      .clk, .rst_n, .irq_set, .reset_req, .cur_pc, .cfg_pc_bytes, .cfg_long_slot,
      .gie_wr, .gie_wdata, .sp_wr, .sp_wdata, .gie, .sp, .pending, .busy,
      .mem_we, .mem_addr, .mem_wdata, .taken, .taken_vec, .new_pc);

   typedef struct packed {
      logic rr; logic ge; logic [7:0] irq; logic [1:0] pcb; logic lng;
      logic [15:0] spv; logic [23:0] pc;
      logic tk; logic [3:0] vec; logic [23:0] npc; logic [1:0] nb; logic [7:0] pend;
   } row_t;

   localparam row_t TBL [7] = '{
      '{1'b0,1'b1,8'h04,2'd2,1'b1,16'h10FF,24'h001234,1'b1,4'd3,24'd6, 2'd2,8'h00},
      '{1'b0,1'b1,8'hA0,2'd3,1'b0,16'h0200,24'h2ABCDE,1'b1,4'd6,24'd6, 2'd3,8'h80},
      '{1'b1,1'b0,8'h03,2'd1,1'b1,16'h00FF,24'h000055,1'b1,4'd0,24'd0, 2'd1,8'h03},
      '{1'b0,1'b0,8'h01,2'd2,1'b0,16'h0400,24'h000777,1'b0,4'd0,24'd0, 2'd0,8'h01},
      '{1'b0,1'b1,8'h00,2'd3,1'b1,16'h0500,24'h000888,1'b0,4'd0,24'd0, 2'd0,8'h00},
      '{1'b0,1'b1,8'h80,2'd0,1'b1,16'h0600,24'h003456,1'b1,4'd8,24'd16,2'd1,8'h00},
      '{1'b1,1'b1,8'h10,2'd2,1'b0,16'h0700,24'h00BEEF,1'b1,4'd0,24'd0, 2'd2,8'h10}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Runs one entry; the request is accepted at the edge before cycle 1.
   task automatic run_row(input row_t r, input bit poke_busy);
      int wr_cnt = 0, tk_cnt = 0, tk_cyc = 0;
      logic [3:0] got_vec = '0;
      logic [PCW-1:0] got_pc = '0;
      do_reset();
      sp_wr = 1'b1; sp_wdata = r.spv; gie_wr = 1'b1; gie_wdata = r.ge;
      irq_set = r.irq; cfg_pc_bytes = r.pcb; cfg_long_slot = r.lng; cur_pc = r.pc[PCW-1:0];
      @(negedge clk);
      sp_wr = 1'b0; gie_wr = 1'b0; irq_set = '0; reset_req = r.rr;
      @(negedge clk);
      reset_req = 1'b0;
      for (int c = 1; c <= 6; c++) begin
         if (poke_busy && c == 1) begin
            // R12: writes while busy must be ignored; R10: new request ORed in
            sp_wr = 1'b1; sp_wdata = 16'h1111; gie_wr = 1'b1; gie_wdata = 1'b1; irq_set = 8'h40;
         end else begin
            sp_wr = 1'b0; gie_wr = 1'b0; irq_set = '0;
         end
         if (mem_we) begin
            chk(c == wr_cnt + 1, "R11 write cycle", c, wr_cnt + 1);
            chk(mem_addr == SPW'(r.spv - 16'(wr_cnt)), "R6 push address", mem_addr, r.spv - 16'(wr_cnt));
            chk(mem_wdata == 8'(r.pc >> (8 * wr_cnt)), "R6 push byte", mem_wdata, 8'(r.pc >> (8 * wr_cnt)));
            wr_cnt++;
         end
         if (taken) begin
            tk_cnt++; tk_cyc = c; got_vec = taken_vec; got_pc = new_pc;
         end
         @(negedge clk);
      end
      sp_wr = 1'b0; gie_wr = 1'b0; irq_set = '0;
      chk(wr_cnt == int'(r.nb), "R7 push count", wr_cnt, r.nb);
      chk(tk_cnt == int'(r.tk), "R3/R11 taken pulses", tk_cnt, r.tk);
      if (r.tk) begin
         chk(tk_cyc == int'(r.nb) + 1, "R11 taken cycle", tk_cyc, int'(r.nb) + 1);
         chk(got_vec == r.vec, "R4/R2 vector", got_vec, r.vec);
         chk(got_pc == r.npc[PCW-1:0], "R5 new pc", got_pc, r.npc);
         chk(gie == 1'b0, "R8 enable cleared", gie, 0);
      end else begin
         chk(gie == r.ge, "R3 enable kept", gie, r.ge);
      end
      chk(sp == SPW'(r.spv - 16'(r.nb)), "R6 final sp", sp, r.spv - 16'(r.nb));
      if (poke_busy)
         chk(pending == (r.pend | 8'h40), "R10 pending ORed in busy", pending, r.pend | 8'h40);
      else
         chk(pending == r.pend, "R9/R2 pending after", pending, r.pend);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk(pending == '0, "R1 pending", pending, 0);
      chk(gie == 1'b0, "R1 gie", gie, 0);
      chk(sp == SPI, "R1 sp", sp, SPI);
      chk(!busy && !mem_we && !taken, "R1 idle outputs", {busy, mem_we, taken}, 0);

      foreach (TBL[i]) run_row(TBL[i], 1'b0);

      // R12 and R10: three-byte entry with writes and a new request during busy
      run_row('{1'b0,1'b1,8'h02,2'd3,1'b1,16'h0300,24'h0A0B0C,1'b1,4'd2,24'd4,2'd3,8'h00}, 1'b1);
      chk(sp != 16'h1111, "R12 sp write ignored", sp, 16'h02FD);

      // R10 on a pending bit while idle with interrupts off
      do_reset();
      irq_set = 8'h81;
      @(negedge clk);
      irq_set = '0;
      chk(pending == 8'h81, "R10 idle set", pending, 8'h81);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule